// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Unit

This unit gives each of several cores a word-wide mailbox of independent doorbell bits for inter-processor interrupts. A core rings another core by writing a bit pattern to that core's set address. Every 1 in the pattern raises the matching doorbell, and every 0 leaves its bit as it was. To ring several cores, a sender writes the same pattern to each target's set address in turn. The receiving core reads its mailbox through its clear address and acknowledges doorbells by writing ones back to that same address.

Each mailbox has an interrupt output. It is high while the mailbox holds any raised bit and the core's enable bit is on. Each mailbox also reports a valid flag and the index of its lowest raised bit, because that doorbell is serviced first. The register bus has two write ports so that two bus masters can write in the same cycle. When one master raises a bit and the other clears the same bit in the same cycle, the raise wins and the doorbell is not lost.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every mailbox and every enable bit is 0, every interrupt output is low and every pending valid flag is low.
- R2: A write to address 0x40 + 16*c raises each bit of mailbox c that is 1 in the data. Bits written as 0 keep their value.
- R3: A read of address 0x80 + 16*c returns mailbox c. A write to that address clears each bit that is 1 in the data and leaves the others unchanged.
- R4: The enable of core c is bit 0 at address 0x00 + 4*c. It can be written and read back, and its upper read bits are 0. If both ports write it in the same cycle, port 1 wins.
- R5: irq[c] is 1 exactly when mailbox c is nonzero and enable c is 1.
- R6: pend_vld[c] is 1 when mailbox c is nonzero. pend_idx[5*c +: 5] then holds the position of its lowest 1 bit.
- R7: When one port raises a bit of a mailbox and the other port clears the same bit in the same cycle, the bit ends at 1. Other bits that are cleared in that cycle still clear.
- R8: Writing the registers of one core never changes another core's mailbox or enable.
- R9: A write to an address that is not one of the registers above has no effect. A read of a set address or of an unmapped address returns 0.
- R10: Raises to one mailbox from both ports in the same cycle combine, and the result is their union.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 2 | Write strobe for each write port |
| wr_addr | input | 16 | Byte address for each port; port p uses bits [8p+7:8p] |
| wr_data | input | 64 | Write data for each port; port p uses bits [32p+31:32p] |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 4 | Interrupt request for each core |
| pend_vld | output | 4 | Mailbox c holds at least one raised bit |
| pend_idx | output | 20 | Index of the lowest raised bit; 5 bits per core |

## Verification
The assertions check several rules on every cycle. A raised bit is present in the next cycle. A bit that was cleared but not raised is gone. A bit that was neither raised nor cleared keeps its value. The reported index always points at a set bit with no set bit below it, and an interrupt never fires while its enable is off. Only the bench scenarios show the following: the address map and its stride, read-back through the clear address, independence between cores, multi-target ringing, ignored addresses, and the two-port cases in which a raise meets a clear or a second raise.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int MBX_STRIDE = 16;
    localparam int ENA_STRIDE = 4;

    function automatic int idx_width(input int bits);
        return (bits > 1) ? $clog2(bits) : 1;
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int NPORT  = 2,
    parameter int NCORE  = 4,
    parameter int BITS   = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ENA_BASE = 8'h00,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'h80
) (
    input  logic [NPORT-1:0]        wr_en_i,
    input  logic [NPORT*ADDR_W-1:0] wr_addr_i,
    input  logic [NPORT*BITS-1:0]   wr_data_i,
    output logic [NCORE*BITS-1:0]   set_o,
    output logic [NCORE*BITS-1:0]   clr_o,
    output logic [NCORE-1:0]        en_we_o,
    output logic [NCORE-1:0]        en_wd_o
);
    import mbx_pkg::*;

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(int'(SET_BASE) + MBX_STRIDE * c);
        localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(int'(CLR_BASE) + MBX_STRIDE * c);
        localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(int'(ENA_BASE) + ENA_STRIDE * c);

        always_comb begin
            set_o[c*BITS +: BITS] = '0;
            clr_o[c*BITS +: BITS] = '0;
            en_we_o[c]            = 1'b0;
            en_wd_o[c]            = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                if (wr_en_i[p]) begin
                    if (wr_addr_i[p*ADDR_W +: ADDR_W] == SET_A)
                        set_o[c*BITS +: BITS] = set_o[c*BITS +: BITS] | wr_data_i[p*BITS +: BITS];
                    if (wr_addr_i[p*ADDR_W +: ADDR_W] == CLR_A)
                        clr_o[c*BITS +: BITS] = clr_o[c*BITS +: BITS] | wr_data_i[p*BITS +: BITS];
                    if (wr_addr_i[p*ADDR_W +: ADDR_W] == ENA_A) begin
                        en_we_o[c] = 1'b1;
                        en_wd_o[c] = wr_data_i[p*BITS];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
    parameter int BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] set_i,
    input  logic [BITS-1:0] clr_i,
    input  logic            en_we_i,
    input  logic            en_wd_i,
    output logic [BITS-1:0] box_o,
    output logic            en_o
);
    typedef struct packed {
        logic [BITS-1:0] box;
        logic            en;
    } cell_t;

    cell_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.box = (s_q.box & ~clr_i) | set_i;
        if (en_we_i) s_d.en = en_wd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign box_o = s_q.box;
    assign en_o  = s_q.en;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((box_o & $past(set_i)) == $past(set_i))); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((box_o & $past(clr_i & ~set_i)) == '0)); // R3
    AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((box_o ^ $past(box_o)) & ~$past(set_i | clr_i)) == '0)); // R2
endmodule

// File: rtl/mbx_lowbit.sv
module mbx_lowbit #(
    parameter int BITS = 32,
    localparam int IDX_W = mbx_pkg::idx_width(BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BITS-1:0]  vec_i,
    output logic             vld_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        vld_o = |vec_i;
        idx_o = '0;
        for (int i = BITS - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end

    AST_LOWEST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (vec_i[idx_o] &&
                   ((vec_i & ((BITS'(1) << idx_o) - BITS'(1))) == '0))); // R6
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
    parameter int NPORT  = 2,
    parameter int NCORE  = 4,
    parameter int BITS   = 32,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ENA_BASE = 8'h00,
    parameter logic [ADDR_W-1:0] SET_BASE = 8'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE = 8'h80,
    localparam int IDX_W = mbx_pkg::idx_width(BITS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        wr_en,
    input  logic [NPORT*ADDR_W-1:0] wr_addr,
    input  logic [NPORT*BITS-1:0]   wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [BITS-1:0]         rd_data,
    output logic [NCORE-1:0]        irq,
    output logic [NCORE-1:0]        pend_vld,
    output logic [NCORE*IDX_W-1:0]  pend_idx
);
    import mbx_pkg::*;

    logic [NCORE*BITS-1:0] set_m, clr_m, box_all;
    logic [NCORE-1:0]      en_we, en_wd, en_q;

    mbx_decode #(
        .NPORT(NPORT), .NCORE(NCORE), .BITS(BITS), .ADDR_W(ADDR_W),
        .ENA_BASE(ENA_BASE), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
    ) u_dec (
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .set_o(set_m), .clr_o(clr_m), .en_we_o(en_we), .en_wd_o(en_wd)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_mbx
        mbx_cell #(.BITS(BITS)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_m[c*BITS +: BITS]), .clr_i(clr_m[c*BITS +: BITS]),
            .en_we_i(en_we[c]), .en_wd_i(en_wd[c]),
            .box_o(box_all[c*BITS +: BITS]), .en_o(en_q[c])
        );

        mbx_lowbit #(.BITS(BITS)) u_low (
            .clk(clk), .rst_n(rst_n),
            .vec_i(box_all[c*BITS +: BITS]),
            .vld_o(pend_vld[c]), .idx_o(pend_idx[c*IDX_W +: IDX_W])
        );

        assign irq[c] = pend_vld[c] & en_q[c];

        AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> (en_q[c] && box_all[c*BITS +: BITS] != '0)); // R5
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCORE; c++) begin
            if (rd_addr == ADDR_W'(int'(CLR_BASE) + MBX_STRIDE * c))
                rd_data = box_all[c*BITS +: BITS];
            if (rd_addr == ADDR_W'(int'(ENA_BASE) + ENA_STRIDE * c))
                rd_data = BITS'(en_q[c]);
        end
    end
endmodule

// File: tb/tb_mbx_doorbell.sv
`timescale 1ns/1ps
module tb_mbx_doorbell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_en = '0;
    logic [15:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq, pend_vld;
    logic [19:0] pend_idx;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_box [4];
    logic        exp_en  [4];

    always #2.5 clk = ~clk;

    mbx_doorbell dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .pend_vld(pend_vld), .pend_idx(pend_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr1(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 2'b01; wr_addr = {8'h00, a}; wr_data = {32'h0, d};
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr2(input logic [7:0] a0, input logic [31:0] d0,
                       input logic [7:0] a1, input logic [31:0] d1);
        @(negedge clk);
        wr_en = 2'b11; wr_addr = {a1, a0}; wr_data = {d1, d0};
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    function automatic logic [4:0] low_idx(input logic [31:0] v);
        logic [4:0] r = '0;
        for (int i = 31; i >= 0; i--) if (v[i]) r = 5'(i);
        return r;
    endfunction

    task automatic verify(input string req);
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h80 + 16 * c), d);
            chk({req, " box"}, d, exp_box[c]);
            rd(8'(4 * c), d);
            chk({req, " R4 en"}, d, {31'h0, exp_en[c]});
            chk({req, " R6 vld"}, {31'h0, pend_vld[c]}, {31'h0, exp_box[c] != 0});
            if (exp_box[c] != 0)
                chk({req, " R6 idx"}, {27'h0, pend_idx[c*5 +: 5]}, {27'h0, low_idx(exp_box[c])});
            chk({req, " R5 irq"}, {31'h0, irq[c]}, {31'h0, (exp_box[c] != 0) && exp_en[c]});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin exp_box[c] = '0; exp_en[c] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        verify("R1");

        // R2 R3 R6 R8: single-bit sweep over every core and bit
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 32; b++) begin
                wr1(8'(8'h40 + 16 * c), 32'h1 << b);
                rd(8'(8'h80 + 16 * c), d);
                chk("R2 sweep set", d, 32'h1 << b);
                chk("R6 sweep idx", {27'h0, pend_idx[c*5 +: 5]}, 32'(b));
                chk("R8 others empty", {28'h0, pend_vld}, 32'h1 << c);
                wr1(8'(8'h80 + 16 * c), 32'h1 << b);
                rd(8'(8'h80 + 16 * c), d);
                chk("R3 sweep clr", d, 32'h0);
            end
        end

        // R4 R5: enables
        wr1(8'h04, 32'hFFFF_FFFF); exp_en[1] = 1'b1;
        wr1(8'h0C, 32'h1);         exp_en[3] = 1'b1;
        verify("R4 enable");
        // R8: multi-target ring
        for (int c = 1; c < 4; c++) begin
            wr1(8'(8'h40 + 16 * c), 32'h0000_A0A0);
            exp_box[c] = 32'h0000_A0A0;
        end
        verify("R8 multi-target");
        // R2: zeros keep
        wr1(8'h50, 32'h0); verify("R2 zero write");
        wr1(8'h50, 32'h8000_0001); exp_box[1] |= 32'h8000_0001; verify("R2 accumulate");
        // R3: partial clear
        wr1(8'h90, 32'h0000_2001); exp_box[1] &= ~32'h0000_2001; verify("R3 partial clear");
        // R5: disable drops irq while mailbox holds bits
        wr1(8'h04, 32'h0); exp_en[1] = 1'b0; verify("R5 disabled");
        // R7: raise meets clear of same bit on other port
        wr2(8'h60, 32'h0000_0080, 8'hA0, 32'h0000_2080);
        exp_box[2] = (exp_box[2] & ~32'h0000_2000) | 32'h80;
        verify("R7 set wins");
        wr2(8'hA0, 32'h0000_0004, 8'h60, 32'h0000_0004);
        exp_box[2] |= 32'h4; verify("R7 swapped ports");
        // R10: two raises combine
        wr2(8'h40, 32'h0000_0F00, 8'h40, 32'h00F0_0000);
        exp_box[0] = 32'h00F0_0F00; verify("R10 union");
        // R4: same-cycle enable writes, port 1 wins
        wr2(8'h00, 32'h1, 8'h00, 32'h0); verify("R4 port1 wins");
        // R9: unmapped and misaligned addresses ignored
        wr1(8'h44, 32'hFFFF_FFFF); wr1(8'h84, 32'hFFFF_FFFF);
        wr1(8'h02, 32'h1); wr1(8'hF0, 32'hFFFF_FFFF);
        verify("R9 ignored");
        rd(8'h50, d); chk("R9 set reads zero", d, 32'h0);
        rd(8'hC4, d); chk("R9 unmapped reads zero", d, 32'h0);
        // R1: reset clears everything again
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        for (int c = 0; c < 4; c++) begin exp_box[c] = '0; exp_en[c] = 1'b0; end
        @(negedge clk);
        verify("R1 re-reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule